// File: doc/BRIEF.md
# Envelope Global Rate Timer

This block is the chip-wide timing source that every envelope generator shares. It advances once per audio sample, on each cycle where `sample_en` is high. Inside it are a wide step counter, a remainder flag that records a counter wrap, and a two-state phase machine whose state is the parity bit. From these it produces a small shift-add code. Each envelope generator compares that code with its own rate to decide whether a slow rate steps on the current sample. It also produces the parity bit and a free-running sample count, whose low bits select the pattern entry used by fast rates.

The shift-add code is one plus the number of trailing zero bits of the step counter. It is forced to zero when the counter is zero or when the trailing-zero count is above a limit. The step counter advances only on odd samples, so each value normally lasts two samples. When the counter wraps, the remainder flag makes it advance on the next sample as well, whatever the parity. All outputs are registered. The code is taken from the counter value held before the sample's update. The parity output is the phase after that sample's toggle. Envelope generators therefore use values that were settled on the previous sample.

Phase machine states: `PH_EVEN` (parity 0) and `PH_ODD` (parity 1). Transitions: `EVEN_TO_ODD` and `ODD_TO_EVEN`, each taken on every enabled sample. With no enable the state holds.

Top module: `eg_rate_timer`

## Requirements
- R1: After reset, `eg_add_o`, `eg_parity_o` and `sample_cnt_o` are 0. The step counter and the remainder flag are 0. The first two enabled samples therefore give code 0, and the next two give code 1.
- R2: On an enabled sample where the step counter is zero, `eg_add_o` becomes 0.
- R3: On an enabled sample where the step counter is nonzero with t trailing zero bits and t ≤ TZ_LIMIT (12), `eg_add_o` becomes t+1.
- R4: On an enabled sample where the step counter is nonzero with more than TZ_LIMIT trailing zero bits, `eg_add_o` becomes 0.
- R5: The step counter advances by one on an enabled sample only when the parity state is `PH_ODD` or the remainder flag is set. Otherwise it holds. A value reached from an even phase with no remainder therefore produces the same code on two consecutive samples.
- R6: An advance from all ones wraps the step counter to 0 and sets the remainder flag. Any other advance adds 1 and clears the flag. After a wrap, the counter values 0 and 1 each last only one sample.
- R7: `eg_parity_o` toggles on every enabled sample, after the counter update has used the old value.
- R8: `sample_cnt_o` increments by 1 on every enabled sample and wraps modulo 2^SAMP_W.
- R9: On a cycle with `sample_en` low, no output and no internal state changes.
- R10: The code produced on a sample is taken from the counter value before that sample's advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle pulse per audio sample |
| eg_add_o | output | ADD_W (4) | Registered shift-add code |
| eg_parity_o | output | 1 | Registered sample parity |
| sample_cnt_o | output | SAMP_W (16) | Free-running sample count |

## Verification
The bench builds the block with a 14-bit step counter, a 10-bit sample counter and the default trailing-zero limit of 12. With these values a full counter period, about 32,800 samples, fits in one run. The sweep passes through every counter value, including those with exactly 12 and 13 trailing zeros. It also covers the wrap from all ones and the skipped parity phase that the remainder flag causes, along with several sample-counter wraps. Idle cycles are inserted between samples to show that nothing moves without an enable.

// File: rtl/eg_timer_pkg.sv
package eg_timer_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

endpackage

// File: rtl/eg_tz_encoder.sv
module eg_tz_encoder #(
    parameter int CNT_W    = 36,
    parameter int TZ_LIMIT = 12,
    parameter int ADD_W    = $clog2(TZ_LIMIT + 2)
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [ADD_W-1:0] add_o
);
    localparam int TZ_W = $clog2(CNT_W + 1);

    logic [TZ_W-1:0] tz;
    logic            found;

    // lowest set bit wins
    always_comb begin
        tz    = '0;
        found = 1'b0;
        for (int i = 0; i < CNT_W; i++) begin
            if (!found && cnt_i[i]) begin
                tz    = TZ_W'(i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        if (!found)
            add_o = '0;
        else if (int'(tz) > TZ_LIMIT)
            add_o = '0;
        else
            add_o = ADD_W'(tz) + ADD_W'(1);
    end
endmodule

// File: rtl/eg_step_counter.sv
module eg_step_counter #(
    parameter int CNT_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             odd_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             rem_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             rem_q;
    logic             adv;

    assign adv = sample_en && (odd_i || rem_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rem_q <= 1'b0;
        end else if (adv) begin
            if (&cnt_q) begin
                cnt_q <= '0;
                rem_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                rem_q <= 1'b0;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign rem_o = rem_q;
endmodule

// File: rtl/eg_sample_counter.sv
module eg_sample_counter #(
    parameter int SAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    output logic [SAMP_W-1:0] cnt_o
);
    logic [SAMP_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (sample_en)
            cnt_q <= cnt_q + SAMP_W'(1);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/eg_rate_timer.sv
module eg_rate_timer #(
    parameter int CNT_W    = 36,
    parameter int SAMP_W   = 16,
    parameter int TZ_LIMIT = 12,
    parameter int ADD_W    = $clog2(TZ_LIMIT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    output logic [ADD_W-1:0]  eg_add_o,
    output logic              eg_parity_o,
    output logic [SAMP_W-1:0] sample_cnt_o
);
    import eg_timer_pkg::*;

    phase_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_val;
    logic             rem_val;
    logic [ADD_W-1:0] add_comb;
    logic [ADD_W-1:0] add_q;

    // phase state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PH_EVEN;
        else
            state_q <= state_d;
    end

    // transitions EVEN_TO_ODD / ODD_TO_EVEN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_EVEN: if (sample_en) state_d = PH_ODD;
            PH_ODD:  if (sample_en) state_d = PH_EVEN;
        endcase
    end

    // outputs of the phase machine
    always_comb begin
        unique case (state_q)
            PH_EVEN: eg_parity_o = 1'b0;
            PH_ODD:  eg_parity_o = 1'b1;
        endcase
    end

    eg_step_counter #(.CNT_W(CNT_W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .odd_i     (state_q == PH_ODD),
        .cnt_o     (cnt_val),
        .rem_o     (rem_val)
    );

    eg_tz_encoder #(.CNT_W(CNT_W), .TZ_LIMIT(TZ_LIMIT), .ADD_W(ADD_W)) u_tz (
        .cnt_i (cnt_val),
        .add_o (add_comb)
    );

    // code sampled from the pre-advance counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            add_q <= '0;
        else if (sample_en)
            add_q <= add_comb;
    end

    assign eg_add_o = add_q;

    eg_sample_counter #(.SAMP_W(SAMP_W)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .cnt_o     (sample_cnt_o)
    );
endmodule

// File: rtl/eg_rate_timer_chk.sv
module eg_rate_timer_chk #(
    parameter int CNT_W    = 36,
    parameter int SAMP_W   = 16,
    parameter int TZ_LIMIT = 12,
    parameter int ADD_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_en,
    input logic [ADD_W-1:0]  eg_add_o,
    input logic              eg_parity_o,
    input logic [SAMP_W-1:0] sample_cnt_o,
    input logic [CNT_W-1:0]  cnt_val,
    input logic              rem_val
);
    AST_PARITY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> eg_parity_o != $past(eg_parity_o)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(eg_add_o) && $stable(eg_parity_o) && $stable(sample_cnt_o) && $stable(cnt_val) && $stable(rem_val)); // R9

    AST_SAMPLE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> sample_cnt_o == $past(sample_cnt_o) + SAMP_W'(1)); // R8

    AST_ADD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(eg_add_o) <= TZ_LIMIT + 1); // R3

    AST_ZERO_CNT_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && cnt_val == '0 |=> eg_add_o == '0); // R2

    AST_EVEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && !eg_parity_o && !rem_val |=> $stable(cnt_val)); // R5

    AST_WRAP_SETS_REM: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && eg_parity_o && (&cnt_val) |=> cnt_val == '0 && rem_val); // R6

    AST_REM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && rem_val |=> cnt_val == CNT_W'(1) && !rem_val); // R6
endmodule

bind eg_rate_timer eg_rate_timer_chk #(
    .CNT_W(CNT_W), .SAMP_W(SAMP_W), .TZ_LIMIT(TZ_LIMIT), .ADD_W(ADD_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_en    (sample_en),
    .eg_add_o     (eg_add_o),
    .eg_parity_o  (eg_parity_o),
    .sample_cnt_o (sample_cnt_o),
    .cnt_val      (cnt_val),
    .rem_val      (rem_val)
);

// File: tb/test_eg_rate_timer.sv
`timescale 1ns/1ps
module test_eg_rate_timer;
    localparam int CNT_W    = 14;
    localparam int SAMP_W   = 10;
    localparam int TZ_LIMIT = 12;
    localparam int ADD_W    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_en = 1'b0;
    logic [ADD_W-1:0]  eg_add_o;
    logic              eg_parity_o;
    logic [SAMP_W-1:0] sample_cnt_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    int m_cnt = 0, m_par = 0, m_rem = 0, m_samp = 0, m_add = 0;
    int seen_tz12 = 0, seen_tz13 = 0, seen_wrap = 0;

    always #4 clk = ~clk;

    eg_rate_timer #(.CNT_W(CNT_W), .SAMP_W(SAMP_W), .TZ_LIMIT(TZ_LIMIT), .ADD_W(ADD_W)) i_eg_rate_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_en    (sample_en),
        .eg_add_o     (eg_add_o),
        .eg_parity_o  (eg_parity_o),
        .sample_cnt_o (sample_cnt_o)
    );

    function automatic int tz_of(int v);
        for (int i = 0; i < CNT_W; i++)
            if (((v >> i) & 1) != 0) return i;
        return CNT_W;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (model cnt %0d)", req, act, exp, m_cnt);
        end
    endtask

    task automatic check_all(string add_req);
        chk(add_req, int'(eg_add_o), m_add);
        chk("R7 parity", int'(eg_parity_o), m_par);
        chk("R8 sample count", int'(sample_cnt_o), m_samp);
    endtask

    // one enabled sample plus model update
    task automatic do_sample();
        int t;
        string req;
        t = tz_of(m_cnt);
        if (m_cnt == 0) begin
            m_add = 0; req = "R2 zero counter";
        end else if (t > TZ_LIMIT) begin
            m_add = 0; req = "R4 tz above limit"; seen_tz13++;
        end else begin
            m_add = t + 1; req = "R3 tz plus one";
            if (t == 12) seen_tz12++;
        end
        if (m_par == 1 || m_rem == 1) begin
            if (m_cnt == (1 << CNT_W) - 1) begin
                m_cnt = 0; m_rem = 1; seen_wrap++;
            end else begin
                m_cnt = m_cnt + 1; m_rem = 0;
            end
        end
        m_par  = m_par ^ 1;
        m_samp = (m_samp + 1) % (1 << SAMP_W);
        sample_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sample_en = 1'b0;
        check_all(req);
    endtask

    task automatic do_idle();
        @(posedge clk);
        @(negedge clk);
        check_all("R9 idle add");
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int exp_seq[6];
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 add", int'(eg_add_o), 0);
        chk("R1 parity", int'(eg_parity_o), 0);
        chk("R1 sample count", int'(sample_cnt_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_idle();
        // R10 / R1: codes from pre-advance counter: 0,0,1,1,2,2
        exp_seq = '{0, 0, 1, 1, 2, 2};
        for (int k = 0; k < 6; k++) begin
            do_sample();
            chk("R10 first codes", int'(eg_add_o), exp_seq[k]);
        end
        // R5: counter value held two samples (code repeats on 2 and 2)
        // full period sweep including wrap (R6), with idle gaps (R9)
        for (int k = 0; k < 2 * (1 << CNT_W) + 40; k++) begin
            do_sample();
            if (k % 7 == 3) do_idle();
        end
        chk("R3 saw tz 12", int'(seen_tz12 > 0), 1);
        chk("R4 saw tz 13", int'(seen_tz13 > 0), 1);
        chk("R6 saw wrap", int'(seen_wrap > 0), 1);
        // R6: after wrap the counter is mid-sweep; parity phase shifted
        chk("R5 post-wrap counter small", int'(m_cnt < 40), 1);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule